// File: doc/BRIEF.md
# Weight-Stationary 2x2 Systolic Multiply Array

This block is a small matrix-vector engine built from four multiply-accumulate cells laid out in two rows and two columns. Every cell holds one signed 8-bit weight. Two activations arrive together on each valid cycle. Row 0's activation enters the left cell of row 0, and row 1's activation enters the left cell of row 1 one cycle later. Each activation then hops one register to the right. Partial sums start at zero in the top row and move down one register per row. The bottom cell of each column drives a registered 32-bit signed sum for that column.

Weights are not written in parallel. During a load phase, the weight inputs shift down two column paths. A small sequencer produces a capture strobe per column. Column 0 captures on the second load cycle and column 1 on the third, which forms a diagonal wavefront. On a capture, the top cell of the column takes the value on its column input in that cycle. The bottom cell takes the value that was on the same input one cycle earlier. Captured weights stay fixed until the next load phase, so a matrix loaded once serves any number of vectors. Those vectors may be issued one per cycle.

Top module: `ws_mac_grid2`

## Requirements
- R1: A synchronous active-high reset clears all weights, activation stages, partial sums and valid flags. After reset both sums read 0 with their valid flags low, and a vector computed before any load gives 0 on both columns.
- R2: Load cycles are counted from the first cycle with `load_en` high (that cycle is 0). Column 0 captures in load cycle 1. Its top weight W00 becomes the value of `wcol0` in that cycle, and its bottom weight W10 becomes the value of `wcol0` in load cycle 0.
- R3: Column 1 captures in load cycle 2, one cycle after column 0. Its top weight W01 becomes `wcol1` in load cycle 2, and its bottom weight W11 becomes `wcol1` in load cycle 1.
- R4: Weights do not change in any cycle without a capture. The weight inputs are ignored while `load_en` is low and in load cycle 3 and later of a held `load_en`.
- R5: If `load_en` drops after exactly two load cycles, column 0 takes its new weights and column 1 keeps its previous weights.
- R6: For a vector issued with `in_valid` high in cycle t, `valid_col0` is high in cycle t+2 and `sum_col0` = a0*W00 + a1*W10. Here a0 is `act_row0` and a1 is `act_row1`, both taken as two's-complement 8-bit values, and every product is sign-extended to 32 bits. `valid_col0` is low two cycles after a cycle with `in_valid` low.
- R7: For the same vector, `valid_col1` is high in cycle t+3 and `sum_col1` = a0*W01 + a1*W11, with the same sign rules. `valid_col1` is low three cycles after a cycle with `in_valid` low.
- R8: Vectors may be issued in consecutive cycles or with gaps, and each one produces its own correct result in its own output cycle.
- R9: A vector issued in the cycle just before load cycle 0 is computed entirely with the old weights. A vector issued in load cycle 2 or later is computed entirely with the new weights.
- R10: Extreme operands do not wrap. With all four weights and both activations at -128, each column gives 32768. With activations 127 and -128 against weights of -128, each column gives 128.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| load_en | input | 1 | Weight load phase enable |
| wcol0 | input | DATA_W | Weight input for column 0's path |
| wcol1 | input | DATA_W | Weight input for column 1's path |
| act_row0 | input | DATA_W | Row 0 activation |
| act_row1 | input | DATA_W | Row 1 activation (skewed internally) |
| in_valid | input | 1 | Activation pair is valid |
| sum_col0 | output | ACC_W | Column 0 result |
| sum_col1 | output | ACC_W | Column 1 result |
| valid_col0 | output | 1 | Column 0 result valid |
| valid_col1 | output | 1 | Column 1 result valid |

## Verification
A weight load and a computation can overlap. The two column captures fall one cycle apart, so a vector still moving through the array could read a mix of old and new weights. The bench provokes this by issuing one vector in the cycle before the load starts and others in the third load cycle and the cycle after it. It judges each column sum against the value computed from the old or the new matrix, as R9 states. Random streams with random gaps between consecutive loads, held and cut-short loads, and garbage on the weight inputs outside capture cycles complete the mix.

// File: rtl/ws_grid_pkg.sv
package ws_grid_pkg;
  // Array edge length; the diagonal capture schedule is built for two.
  localparam int GRID = 2;
  // Load sequencer step counter: counts 0..GRID+1 and then saturates.
  localparam int STEP_LAST = GRID + 1;
  localparam int STEP_W = $clog2(STEP_LAST + 1);
  typedef logic [STEP_W-1:0] step_t;
endpackage

// File: rtl/ws_load_seq.sv
module ws_load_seq
  import ws_grid_pkg::*;
(
  input  logic            clk,
  input  logic            rst,
  input  logic            load_en,
  output logic [GRID-1:0] cap
);
  step_t step;

  // Counts the load cycles; a low load_en restarts the count.
  always_ff @(posedge clk) begin
    if (rst || !load_en) begin
      step <= '0;
    end else if (step != step_t'(STEP_LAST)) begin
      step <= step + 1'b1;
    end
  end

  // Column c captures in load cycle c+1: the diagonal wavefront.
  for (genvar c = 0; c < GRID; c++) begin : g_cap
    assign cap[c] = load_en && (step == step_t'(c + 1));
  end

  // R3: column 1 captures exactly one cycle after column 0
  assert_cap_order_R3: assert property (@(posedge clk) disable iff (rst)
    cap[1] |-> $past(cap[0]));
  // R4: a capture never happens beyond the third load cycle
  assert_cap_window_R4: assert property (@(posedge clk) disable iff (rst)
    $past(cap[1]) |-> !cap[0] && !cap[1]);
endmodule

// File: rtl/ws_weight_col.sv
module ws_weight_col #(
  parameter int DATA_W = 8
) (
  input  logic                     clk,
  input  logic                     rst,
  input  logic                     load_en,
  input  logic                     cap,
  input  logic signed [DATA_W-1:0] w_in,
  output logic signed [DATA_W-1:0] wt_top,
  output logic signed [DATA_W-1:0] wt_bot
);
  logic signed [DATA_W-1:0] shift_q;

  // The column path moves one stage per load cycle.
  always_ff @(posedge clk) begin
    if (rst) begin
      shift_q <= '0;
    end else if (load_en) begin
      shift_q <= w_in;
    end
  end

  // On the capture strobe, the top cell takes the current input and the
  // bottom cell takes the value that passed the top one cycle earlier.
  always_ff @(posedge clk) begin
    if (rst) begin
      wt_top <= '0;
      wt_bot <= '0;
    end else if (cap) begin
      wt_top <= w_in;
      wt_bot <= shift_q;
    end
  end

  // R4: weights stay put in every cycle without a capture
  assert_weight_hold_R4: assert property (@(posedge clk) disable iff (rst)
    !cap |=> $stable(wt_top) && $stable(wt_bot));
endmodule

// File: rtl/ws_mac_cell.sv
module ws_mac_cell #(
  parameter int DATA_W = 8,
  parameter int ACC_W  = 32
) (
  input  logic                     clk,
  input  logic                     rst,
  input  logic signed [DATA_W-1:0] act_in,
  input  logic signed [DATA_W-1:0] wt,
  input  logic signed [ACC_W-1:0]  psum_in,
  output logic signed [ACC_W-1:0]  psum_out
);
  localparam int PROD_W = 2 * DATA_W;

  logic signed [PROD_W-1:0] prod;
  logic signed [ACC_W-1:0]  prod_ext;

  assign prod     = act_in * wt;
  assign prod_ext = {{(ACC_W - PROD_W){prod[PROD_W-1]}}, prod};

  always_ff @(posedge clk) begin
    if (rst) begin
      psum_out <= '0;
    end else begin
      psum_out <= psum_in + prod_ext;
    end
  end
endmodule

// File: rtl/ws_valid_skew.sv
module ws_valid_skew #(
  parameter int DATA_W = 8
) (
  input  logic                     clk,
  input  logic                     rst,
  input  logic                     in_valid,
  input  logic signed [DATA_W-1:0] act_row1,
  output logic signed [DATA_W-1:0] row1_dly,
  output logic                     valid_col0,
  output logic                     valid_col1
);
  logic [2:0] vld_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      vld_q    <= '0;
      row1_dly <= '0;
    end else begin
      vld_q    <= {vld_q[1:0], in_valid};
      row1_dly <= act_row1;
    end
  end

  // Column 0 completes after two register stages, column 1 after three.
  assign valid_col0 = vld_q[1];
  assign valid_col1 = vld_q[2];
endmodule

// File: rtl/ws_mac_grid2.sv
module ws_mac_grid2
  import ws_grid_pkg::*;
#(
  parameter int DATA_W = 8,
  parameter int ACC_W  = 32
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              load_en,
  input  logic [DATA_W-1:0] wcol0,
  input  logic [DATA_W-1:0] wcol1,
  input  logic [DATA_W-1:0] act_row0,
  input  logic [DATA_W-1:0] act_row1,
  input  logic              in_valid,
  output logic [ACC_W-1:0]  sum_col0,
  output logic [ACC_W-1:0]  sum_col1,
  output logic              valid_col0,
  output logic              valid_col1
);
  logic [GRID-1:0]          cap;
  logic signed [DATA_W-1:0] w_in   [GRID];
  logic signed [DATA_W-1:0] wmat   [GRID][GRID];
  logic signed [DATA_W-1:0] row_in [GRID];
  logic signed [DATA_W-1:0] row1_dly;
  logic signed [DATA_W-1:0] hop_q  [GRID][GRID-1];
  logic signed [DATA_W-1:0] lane   [GRID][GRID];
  logic signed [ACC_W-1:0]  psum_o [GRID][GRID];

  assign w_in[0]   = wcol0;
  assign w_in[1]   = wcol1;
  assign row_in[0] = act_row0;
  assign row_in[1] = row1_dly;

  ws_load_seq u_seq (
    .clk     (clk),
    .rst     (rst),
    .load_en (load_en),
    .cap     (cap)
  );

  for (genvar c = 0; c < GRID; c++) begin : g_col
    ws_weight_col #(.DATA_W(DATA_W)) u_wcol (
      .clk     (clk),
      .rst     (rst),
      .load_en (load_en),
      .cap     (cap[c]),
      .w_in    (w_in[c]),
      .wt_top  (wmat[0][c]),
      .wt_bot  (wmat[1][c])
    );
  end

  ws_valid_skew #(.DATA_W(DATA_W)) u_skew (
    .clk        (clk),
    .rst        (rst),
    .in_valid   (in_valid),
    .act_row1   (act_row1),
    .row1_dly   (row1_dly),
    .valid_col0 (valid_col0),
    .valid_col1 (valid_col1)
  );

  // Horizontal activation hops: one register between neighbouring columns.
  always_ff @(posedge clk) begin
    for (int r = 0; r < GRID; r++) begin
      for (int c = 0; c < GRID - 1; c++) begin
        if (rst) hop_q[r][c] <= '0;
        else     hop_q[r][c] <= lane[r][c];
      end
    end
  end

  always_comb begin
    for (int r = 0; r < GRID; r++) begin
      lane[r][0] = row_in[r];
      for (int c = 1; c < GRID; c++) begin
        lane[r][c] = hop_q[r][c-1];
      end
    end
  end

  for (genvar r = 0; r < GRID; r++) begin : g_row
    for (genvar c = 0; c < GRID; c++) begin : g_cell
      logic signed [ACC_W-1:0] psum_in;
      if (r == 0) begin : g_top
        assign psum_in = '0;
      end else begin : g_below
        assign psum_in = psum_o[r-1][c];
      end
      ws_mac_cell #(.DATA_W(DATA_W), .ACC_W(ACC_W)) u_cell (
        .clk      (clk),
        .rst      (rst),
        .act_in   (lane[r][c]),
        .wt       (wmat[r][c]),
        .psum_in  (psum_in),
        .psum_out (psum_o[r][c])
      );
    end
  end

  assign sum_col0 = psum_o[GRID-1][0];
  assign sum_col1 = psum_o[GRID-1][1];

  // R1: reset leaves both columns cleared and invalid
  assert_reset_clear_R1: assert property (@(posedge clk)
    rst |=> !valid_col0 && !valid_col1 && sum_col0 == '0 && sum_col1 == '0);
  // R6: column 0 result follows its input two cycles later
  assert_lat_col0_R6: assert property (@(posedge clk) disable iff (rst)
    in_valid |-> ##2 valid_col0);
  assert_idle_col0_R6: assert property (@(posedge clk) disable iff (rst)
    !in_valid |-> ##2 !valid_col0);
  // R7: column 1 result follows its input three cycles later
  assert_lat_col1_R7: assert property (@(posedge clk) disable iff (rst)
    in_valid |-> ##3 valid_col1);
  assert_idle_col1_R7: assert property (@(posedge clk) disable iff (rst)
    !in_valid |-> ##3 !valid_col1);
endmodule

// File: tb/ws_mac_grid2_bench.sv
module ws_mac_grid2_bench;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        load_en = 1'b0;
  logic [7:0]  wcol0 = '0, wcol1 = '0, act_row0 = '0, act_row1 = '0;
  logic        in_valid = 1'b0;
  logic [31:0] sum_col0, sum_col1;
  logic        valid_col0, valid_col1;

  int n_chk = 0;
  int n_fail = 0;

  always #4 clk = ~clk;  // 125 MHz

  ws_mac_grid2 u_ws_mac_grid2 (
    .clk(clk), .rst(rst), .load_en(load_en), .wcol0(wcol0), .wcol1(wcol1),
    .act_row0(act_row0), .act_row1(act_row1), .in_valid(in_valid),
    .sum_col0(sum_col0), .sum_col1(sum_col1),
    .valid_col0(valid_col0), .valid_col1(valid_col1)
  );

  // Weight model and per-cycle stimulus / expectation tables
  byte mw00, mw01, mw10, mw11;
  bit  st_ld [64];
  bit  st_v  [64];
  byte st_w0 [64], st_w1 [64], st_a0 [64], st_a1 [64];
  int  ex0 [64], ex1 [64];

  function automatic int mac2(byte a0, byte a1, byte wa, byte wb);
    return int'(a0) * int'(wa) + int'(a1) * int'(wb);
  endfunction

  function automatic byte rb();
    return byte'($urandom);
  endfunction

  function automatic void clear_tab();
    for (int k = 0; k < 64; k++) begin
      st_ld[k] = 1'b0; st_v[k] = 1'b0;
      st_w0[k] = rb(); st_w1[k] = rb(); st_a0[k] = rb(); st_a1[k] = rb();
      ex0[k] = 0; ex1[k] = 0;
    end
  endfunction

  function automatic void put(int k, bit ld, byte w0, byte w1, bit v, byte a0, byte a1);
    st_ld[k] = ld; st_w0[k] = w0; st_w1[k] = w1;
    st_v[k] = v; st_a0[k] = a0; st_a1[k] = a1;
    ex0[k] = mac2(a0, a1, mw00, mw10);
    ex1[k] = mac2(a0, a1, mw01, mw11);
  endfunction

  task automatic chk(input bit ok, input string req, input longint actv, input longint expv);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s: actual %0d expected %0d", req, actv, expv);
    end
  endtask

  // Runs n table cycles plus drain; samples at negedge before driving.
  task automatic run_seq(input int n, input string tag);
    for (int k = 0; k < n + 4; k++) begin
      @(negedge clk);
      if (k >= 2 && k - 2 < n && st_v[k-2]) begin
        chk(valid_col0 === 1'b1, {tag, " R6 col0 valid"}, longint'(valid_col0), 1);
        chk($signed(sum_col0) == ex0[k-2], {tag, " R6 col0 sum"},
            longint'($signed(sum_col0)), longint'(ex0[k-2]));
      end else begin
        chk(valid_col0 === 1'b0, {tag, " R6 col0 idle"}, longint'(valid_col0), 0);
      end
      if (k >= 3 && k - 3 < n && st_v[k-3]) begin
        chk(valid_col1 === 1'b1, {tag, " R7 col1 valid"}, longint'(valid_col1), 1);
        chk($signed(sum_col1) == ex1[k-3], {tag, " R7 col1 sum"},
            longint'($signed(sum_col1)), longint'(ex1[k-3]));
      end else begin
        chk(valid_col1 === 1'b0, {tag, " R7 col1 idle"}, longint'(valid_col1), 0);
      end
      if (k < n) begin
        load_en = st_ld[k]; wcol0 = st_w0[k]; wcol1 = st_w1[k];
        in_valid = st_v[k]; act_row0 = st_a0[k]; act_row1 = st_a1[k];
      end else begin
        load_en = 1'b0; in_valid = 1'b0;
        wcol0 = rb(); wcol1 = rb(); act_row0 = rb(); act_row1 = rb();
      end
    end
  endtask

  task automatic do_load(input byte w00, input byte w01, input byte w10, input byte w11,
                         input string tag);
    clear_tab();
    put(0, 1'b1, w10, rb(), 1'b0, 0, 0);
    put(1, 1'b1, w00, w11, 1'b0, 0, 0);
    put(2, 1'b1, rb(), w01, 1'b0, 0, 0);
    run_seq(3, tag);
    mw00 = w00; mw01 = w01; mw10 = w10; mw11 = w11;
  endtask

  task automatic probe(input string tag);
    clear_tab();
    put(0, 1'b0, rb(), rb(), 1'b1, 1, 0);
    put(1, 1'b0, rb(), rb(), 1'b1, 0, 1);
    put(2, 1'b0, rb(), rb(), 1'b1, rb(), rb());
    run_seq(3, tag);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    n_chk++; n_fail++;
    $display("FAIL watchdog: actual timeout expected finish");
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end

  initial begin
    void'($urandom(32'd4242));
    mw00 = 0; mw01 = 0; mw10 = 0; mw11 = 0;
    repeat (4) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    // R1: cleared state after reset
    chk(sum_col0 == 0 && sum_col1 == 0, "R1 sums cleared", longint'(sum_col0 | sum_col1), 0);
    chk(!valid_col0 && !valid_col1, "R1 valids cleared", longint'({valid_col0, valid_col1}), 0);
    // R1: zero weights give zero results
    clear_tab();
    put(0, 1'b0, rb(), rb(), 1'b1, 100, -77);
    put(1, 1'b0, rb(), rb(), 1'b1, -128, 127);
    run_seq(2, "R1");

    // R2 R3: directed diagonal load, cells probed one at a time
    do_load(8'sd11, 8'sd22, 8'sd33, 8'sd44, "R2 R3 load");
    probe("R2 R3");

    // R10: extreme operands
    do_load(-128, -128, -128, -128, "R10 load");
    clear_tab();
    put(0, 1'b0, rb(), rb(), 1'b1, -128, -128);
    put(1, 1'b0, rb(), rb(), 1'b1, 127, -128);
    put(2, 1'b0, rb(), rb(), 1'b1, 127, 127);
    run_seq(3, "R10");
    do_load(127, -128, 127, -128, "R10 load");
    clear_tab();
    put(0, 1'b0, rb(), rb(), 1'b1, -128, -128);
    put(1, 1'b0, rb(), rb(), 1'b1, 127, 127);
    run_seq(2, "R10");

    // R4: load_en held for five cycles; cycles 3 and 4 carry garbage
    begin
      byte a00, a01, a10, a11;
      a00 = rb(); a01 = rb(); a10 = rb(); a11 = rb();
      clear_tab();
      put(0, 1'b1, a10, rb(), 1'b0, 0, 0);
      put(1, 1'b1, a00, a11, 1'b0, 0, 0);
      put(2, 1'b1, rb(), a01, 1'b0, 0, 0);
      put(3, 1'b1, rb(), rb(), 1'b0, 0, 0);
      put(4, 1'b1, rb(), rb(), 1'b0, 0, 0);
      run_seq(5, "R4 load");
      mw00 = a00; mw01 = a01; mw10 = a10; mw11 = a11;
      probe("R4");
    end

    // R5: load cut after two cycles; column 1 keeps its old weights
    begin
      byte b00, b10;
      b00 = rb(); b10 = rb();
      clear_tab();
      put(0, 1'b1, b10, rb(), 1'b0, 0, 0);
      put(1, 1'b1, b00, rb(), 1'b0, 0, 0);
      run_seq(2, "R5 load");
      mw00 = b00; mw10 = b10;
      probe("R5");
    end

    // R9: compute and weight load in overlapping cycles
    begin
      byte c00, c01, c10, c11;
      c00 = rb(); c01 = rb(); c10 = rb(); c11 = rb();
      clear_tab();
      put(0, 1'b0, rb(), rb(), 1'b1, rb(), rb());
      put(1, 1'b1, c10, rb(), 1'b0, 0, 0);
      put(2, 1'b1, c00, c11, 1'b0, 0, 0);
      mw00 = c00; mw01 = c01; mw10 = c10; mw11 = c11;
      put(3, 1'b1, rb(), c01, 1'b1, rb(), rb());
      put(4, 1'b0, rb(), rb(), 1'b1, rb(), rb());
      put(5, 1'b0, rb(), rb(), 1'b1, rb(), rb());
      run_seq(6, "R9");
    end

    // R8: random weights, random streams with gaps
    for (int rnd = 0; rnd < 6; rnd++) begin
      do_load(rb(), rb(), rb(), rb(), "R8 load");
      clear_tab();
      for (int k = 0; k < 24; k++) begin
        put(k, 1'b0, rb(), rb(), ($urandom % 4) != 0, rb(), rb());
      end
      run_seq(24, "R8");
    end

    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end
endmodule